// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an external Ethernet PHY with a single register write. The host writes one 32-bit control word that holds the opcode, the PHY address, the PHY register number and, for a write, the data. The engine then produces the full management frame on the MDC clock and MDIO data lines. When the frame ends, the engine sets a ready bit inside the same control word. For a read, the engine also places the 16 received bits in the low half of that word.

Completion is also recorded in a separate 16-bit status word. Its done flag drives the interrupt output and is cleared by writing 1 to it. MDC comes from a parameterised divider of the system clock and runs only while a frame is in flight. MDIO is driven through a separate output and output enable, so the pad can be bidirectional. The enable is released whenever the PHY owns the line.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0x1000_0000 (ready bit 28 set, all fields zero), the status word reads 0, irq is 0, MDC is low and the MDIO output enable is low.
- R2: Control word fields are data in bits 15:0, PHY register in 20:16, PHY address in 25:21, opcode in 27:26 (01 write, 10 read) and ready in bit 28; bits 31:29 read 0. A write while ready is 1 starts a frame, clears ready and makes the written fields readable at once.
- R3: Every frame is sent MSB first. It consists of PRE_LEN ones (32 by default), then start bits 0 then 1, then the two opcode bits, the 5-bit PHY address and the 5-bit register number.
- R4: For any opcode other than 10, the frame continues with a driven turnaround of 1 then 0 and the 16 data bits. The output enable is high on every bit of the frame.
- R5: For opcode 10, the output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled from mdio_i on the rising MDC edges of the data phase, MSB first, replace control word bits 15:0 when ready returns to 1.
- R6: The MDIO output changes only while MDC is low, that is at a falling edge or before the first rising edge. MDC is low whenever no frame is in flight.
- R7: Each completed frame sets status bit 11 (mask 0x0800), and irq follows that bit. Writing the status word with bit 11 set clears it. Writing it with bit 11 clear leaves it unchanged.
- R8: A control word write while ready is 0 is ignored: the fields keep their values and the frame in flight is not altered.
- R9: Ready returns to 1 exactly 2 x (PRE_LEN+32) x CLK_DIV clock cycles after the clock edge that accepted the write. Each MDC period is 2 x CLK_DIV clocks, and the frame takes 64 MDC periods at the default preamble length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_word | output | 32 | Control word read value |
| stat_wr | input | 1 | Write strobe for the status word |
| stat_wdata | input | 16 | Status write data; bit 11 set clears the done flag |
| stat_word | output | 16 | Status word read value (done flag in bit 11) |
| irq | output | 1 | Completion interrupt, equal to the done flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench builds the controller with CLK_DIV set to 2 and the default 32-bit preamble. Each frame therefore lasts 256 clocks, and every bit of the full 64-bit frame can be recorded at the rising MDC edges by a PHY model in the bench. That PHY model returns chosen read data on the falling edges. With this setup, the exact completion latency, the turnaround ownership and the MSB-first ordering of all fields can be compared bit for bit. The short frame also leaves time for a rejected write placed in the middle of a frame, and for several status clear sequences.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int CW_REG_LSB  = 16;
  localparam int CW_PHY_LSB  = 21;
  localparam int CW_OP_LSB   = 26;
  localparam int CW_RDY_BIT  = 28;
  localparam int ST_DONE_BIT = 11;

  typedef logic [1:0] mgmt_op_t;
  localparam mgmt_op_t OP_WRITE = 2'b01;
  localparam mgmt_op_t OP_READ  = 2'b10;

  typedef struct packed {
    mgmt_op_t    op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t unpack_cmd(input logic [31:0] w);
    mgmt_cmd_t c;
    c.op    = w[CW_OP_LSB +: 2];
    c.phy   = w[CW_PHY_LSB +: 5];
    c.regad = w[CW_REG_LSB +: 5];
    c.data  = w[15:0];
    return c;
  endfunction

  function automatic logic [31:0] frame_tail(input mgmt_cmd_t c);
    logic [1:0]  ta;
    logic [15:0] dat;
    ta  = (c.op == OP_READ) ? 2'b11 : 2'b10;
    dat = (c.op == OP_READ) ? 16'hFFFF : c.data;
    return {2'b01, c.op, c.phy, c.regad, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_PER = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic edge_due;

  generate
    if (HALF_PER <= 1) begin : g_nocnt
      assign edge_due = run;
    end else begin : g_cnt
      localparam int CW = $clog2(HALF_PER);
      localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (!run || cnt == LAST) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end
      assign edge_due = run && (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdc <= 1'b0;
    else if (!run)     mdc <= 1'b0;
    else if (edge_due) mdc <= ~mdc;
  end

  assign rise_tick = edge_due && !mdc;
  assign fall_tick = edge_due && mdc;

  // R6
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int FRAME_W = PRE_LEN + 32;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      shreg   <= '1;
      rd_data <= '0;
      is_rd   <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      shreg <= {{PRE_LEN{1'b1}}, frame_tail(cmd)};
      is_rd <= (cmd.op == OP_READ);
    end else if (busy) begin
      if (rise_tick && is_rd && idx >= DATA_IDX)
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_tick) begin
        if (idx == LAST) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_W-2:0], 1'b1};
        end
      end
    end
  end

  assign done    = busy && fall_tick && (idx == LAST);
  assign mdio_o  = shreg[FRAME_W-1];
  assign mdio_oe = busy && !(is_rd && idx >= TA_IDX);

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  output logic [31:0] ctrl_word,
  input  logic        stat_wr,
  input  logic [15:0] stat_wdata,
  output logic [15:0] stat_word,
  output logic        irq,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  mgmt_cmd_t   cmd_q;
  logic        ready_q;
  logic        done_flag;
  logic        accept;
  logic        eng_busy;
  logic        eng_done;
  logic        rise_tick;
  logic        fall_tick;
  logic [15:0] rd_data;
  logic        unused_bits;

  assign unused_bits = ^{ctrl_wdata[31:28], stat_wdata[15:12], stat_wdata[10:0]};
  assign accept = ctrl_wr && ready_q;

  mdio_clk_div #(.HALF_PER(CLK_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick));

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .cmd(unpack_cmd(ctrl_wdata)),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b1;
    end else if (accept) begin
      cmd_q   <= unpack_cmd(ctrl_wdata);
      ready_q <= 1'b0;
    end else if (eng_done) begin
      ready_q <= 1'b1;
      if (cmd_q.op == OP_READ) cmd_q.data <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             done_flag <= 1'b0;
    else if (eng_done)                      done_flag <= 1'b1;
    else if (stat_wr && stat_wdata[ST_DONE_BIT]) done_flag <= 1'b0;
  end

  assign ctrl_word = {3'b000, ready_q, cmd_q};
  assign stat_word = {4'b0000, done_flag, 11'b0};
  assign irq       = done_flag;

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !ready_q);

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ready_q && !eng_done) |=> $stable(cmd_q));

  // R6
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R7
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (stat_word[11] && irq));

endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  localparam int DIV  = 2;
  localparam int PRE  = 32;
  localparam int NBIT = PRE + 32;
  localparam int EXP_LAT = 2 * NBIT * DIV;
  localparam int NV = 6;
  // {control word, PHY reply}
  localparam logic [47:0] VEC [NV] = '{
    {32'h0420_1200, 16'h0000},
    {32'h0862_0000, 16'h0141},
    {32'h07FF_A5C3, 16'h0000},
    {32'h081F_0000, 16'hFFFF},
    {32'h0AAA_5555, 16'h8001},
    {32'h0555_0000, 16'h1234}
  };

  logic clk = 0, rst_n = 0;
  logic ctrl_wr = 0, stat_wr = 0, mdio_i = 1;
  logic [31:0] ctrl_wdata = 0, ctrl_word;
  logic [15:0] stat_wdata = 0, stat_word;
  logic irq, mdc, mdio_o, mdio_oe;
  int errors = 0, checks = 0, viol = 0, rcnt = 0, lat;
  logic cap_o [NBIT];
  logic cap_oe [NBIT];
  logic [15:0] reply = 0;
  logic prev_mdc = 0, prev_o = 1;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV), .PRE_LEN(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_word(ctrl_word), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_word(stat_word), .irq(irq), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY model: record at rising MDC, answer at falling MDC
  always @(posedge mdc) if (rcnt < NBIT) begin
    cap_o[rcnt] = mdio_o; cap_oe[rcnt] = mdio_oe; rcnt++;
  end
  always @(negedge mdc) begin
    if (rcnt >= PRE + 16 && rcnt < NBIT) mdio_i = reply[NBIT-1-rcnt];
    else if (rcnt >= PRE + 14 && rcnt < NBIT) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  end

  // R6 monitor: MDIO must not move while MDC stays high
  always @(posedge clk) begin
    #1;
    if (mdc && prev_mdc && mdio_o !== prev_o) viol++;
    prev_mdc = mdc; prev_o = mdio_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [31:0] w, input logic [15:0] rep, output int n);
    @(negedge clk);
    reply = rep; rcnt = 0;
    ctrl_wdata = w; ctrl_wr = 1;
    @(posedge clk); #1 ctrl_wr = 0;
    n = 0;
    while (!ctrl_word[28] && n < 5000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic clear_status(input logic [15:0] v);
    @(negedge clk); stat_wdata = v; stat_wr = 1;
    @(negedge clk); stat_wr = 0;
  endtask

  task automatic check_frame(input logic [31:0] w, input string tag);
    logic [NBIT-1:0] ef;
    bit rd;
    int bad_o = 0, bad_oe = 0;
    rd = (w[27:26] == 2'b10);
    ef = {{PRE{1'b1}}, 2'b01, w[27:26], w[25:21], w[20:16],
          rd ? 2'b00 : 2'b10, rd ? 16'h0000 : w[15:0]};
    for (int k = 0; k < NBIT; k++) begin
      bit eoe;
      eoe = !(rd && k >= PRE + 14);
      if (cap_oe[k] !== eoe) bad_oe++;
      if (eoe && cap_o[k] !== ef[NBIT-1-k]) bad_o++;
    end
    chk(bad_o == 0, {tag, " R3 R4 frame bits"}, bad_o, 0);
    chk(bad_oe == 0, {tag, " R4 R5 output enable"}, bad_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(ctrl_word == 32'h1000_0000, "R1 control word", ctrl_word, 32'h1000_0000);
    chk(stat_word == 16'h0 && !irq, "R1 status/irq", {stat_word, 15'b0, irq}, 0);
    chk(!mdc && !mdio_oe, "R1 mdc/oe", {mdc, mdio_oe}, 0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] w, ew;
      logic [15:0] rp;
      w = VEC[v][47:16]; rp = VEC[v][15:0];
      clear_status(16'h0800);
      run_txn(w, rp, lat);
      chk(lat == EXP_LAT, "R9 latency", lat, EXP_LAT);
      check_frame(w, "vec");
      ew = (w[27:26] == 2'b10) ? {4'b0001, w[27:16], rp} : {4'b0001, w[27:0]};
      chk(ctrl_word == ew, "R2 R5 control word after frame", ctrl_word, ew);
      chk(stat_word == 16'h0800 && irq, "R7 done flag set", {stat_word, 15'b0, irq}, 32'h0800_0001);
      chk(!mdc && !mdio_oe, "R6 mdc idle low", {mdc, mdio_oe}, 0);
    end

    // R7 write of 0 leaves done flag, write of 1 clears it
    clear_status(16'hF7FF);
    #1 chk(stat_word == 16'h0800 && irq, "R7 zero write no effect", stat_word, 16'h0800);
    clear_status(16'h0800);
    #1 chk(stat_word == 16'h0 && !irq, "R7 clear by one", stat_word, 0);

    // R2 fields visible at once, ready low; R8 write during frame ignored
    fork
      run_txn(32'h0420_1200, 16'h0, lat);
      begin
        repeat (3) @(posedge clk); #1;
        chk(ctrl_word == 32'h0420_1200, "R2 fields during frame", ctrl_word, 32'h0420_1200);
        repeat (20) @(posedge clk);
        @(negedge clk); ctrl_wdata = 32'h0862_FFFF; ctrl_wr = 1;
        @(negedge clk); ctrl_wr = 0;
        #1 chk(ctrl_word == 32'h0420_1200, "R8 busy write ignored", ctrl_word, 32'h0420_1200);
      end
    join
    chk(lat == EXP_LAT, "R8 latency unchanged", lat, EXP_LAT);
    check_frame(32'h0420_1200, "R8 busy");
    chk(ctrl_word == 32'h1420_1200, "R8 final word", ctrl_word, 32'h1420_1200);
    chk(viol == 0, "R6 mdio stable while mdc high", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule